// File: doc/BRIEF.md
# Instruction Cache Line Lock Controller

This block owns the tag, valid and lock state of a small set-associative instruction cache and carries out software lock maintenance on it. Software first loads a target address register, then writes a command. Three command codes are acted on. One locks the line holding the target byte. If that line is absent, the block fetches it first over a memory read port and then locks it. A second code releases the lock on one line. A third code releases every lock in the cache at once.

Two failure kinds are recorded in sticky flags: a bus error during a fill, and a full set with no unlocked way to take the line. Because the flags are sticky, software can issue a run of lock commands and check the outcome once at the end.

A probe port gives the fetch side its tag lookup and its replacement choice for any line address. Replacement never picks a locked way. A line-write port carries the fill beats to the data array, which is outside this block.

The memory request channel uses valid/ready. The block holds `mem_req_valid` and `mem_req_addr` steady until the memory raises `mem_req_ready`. Only one request is ever outstanding. The response channel is also valid/ready. The block raises `mem_rsp_ready` only while it waits for a beat, so the memory may delay a response for as long as it needs.

Top module: `cache_lock_ctrl`

## Requirements
- R1: `ctl_cmd` 3'b011 is lock-line, 3'b100 is unlock-line and 3'b101 is unlock-all. Any other code changes no lock, valid bit or flag and starts no bus access. Target address bits [3:0] are the byte offset, bits [10:4] are the set index and bits [31:11] are the tag (default geometry).
- R2: A lock-line command whose target hits sets that way's lock bit at the command's clock edge. It makes no memory request, and `busy` stays low.
- R3: A lock-line miss invalidates the chosen victim. It then reads the line as four beats at line base +0, +4, +8 and +12, in that order, and presents each beat on `fill_we`. At the edge that accepts the last good beat, the line becomes valid and locked and `busy` falls.
- R4: A bus error on any fill beat sets `err_bus` and ends the fill at that beat. The line is left invalid.
- R5: A lock-line miss with every way of the target set locked sets `err_nolock`. It changes no line and makes no memory request.
- R6: Unlock-line clears the lock bit of a hitting line at the command's edge, and the line stays valid. A miss changes nothing. Neither case sets a flag.
- R7: Unlock-all clears every lock bit at the command's edge and leaves all valid bits unchanged.
- R8: The victim for a set is never a locked way. The lowest-numbered invalid way is chosen first. Otherwise the set's LRU pointer is used, which names the way after the one most recently filled, provided that way is unlocked. Otherwise the lowest-numbered unlocked way is chosen.
- R9: A lock-line command whose target matches the caching-inhibited region (address & `CI_MASK` == `CI_BASE`, default 0xFFF0_0000) does nothing.
- R10: `busy` is high from a fill-starting command until its fill ends. Command and address writes made while `busy` is high are ignored.
- R11: `err_bus` and `err_nolock` are cleared only by a control write with the matching clear bit set to 1, whether or not the block is busy. A control write with a clear bit at 0 leaves its flag unchanged. A set in the same cycle wins over a clear.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr | input | 1 | Write strobe for the target address register |
| addr_wdata | input | 32 | Target byte address |
| ctl_wr | input | 1 | Write strobe for command and flag clears |
| ctl_cmd | input | 3 | Command code |
| ctl_clr_bus | input | 1 | Write 1 to clear `err_bus` |
| ctl_clr_nolock | input | 1 | Write 1 to clear `err_nolock` |
| busy | output | 1 | Command in progress |
| err_bus | output | 1 | Sticky fill bus error flag |
| err_nolock | output | 1 | Sticky no-lockable-way flag |
| probe_line | input | 28 | Line address (byte address >> 4) to look up |
| probe_hit | output | 1 | Probed line present |
| probe_way | output | 1 | Way holding the probed line |
| probe_locked | output | 1 | Probed line present and locked |
| probe_victim_ok | output | 1 | Probed set has a replaceable way |
| probe_victim_way | output | 1 | Way that replacement would pick |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Beat address of request |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_ready | output | 1 | Block accepts response |
| mem_rsp_data | input | 32 | Response data |
| mem_rsp_err | input | 1 | Response carries a bus error |
| fill_we | output | 1 | Fill beat write to the data array |
| fill_set | output | 7 | Set being filled |
| fill_way | output | 1 | Way being filled |
| fill_beat | output | 2 | Beat number within the line |
| fill_data | output | 32 | Beat data |

## Verification
The hardest situation to reach is a write arriving while a fill is in progress. A fill normally ends within a few cycles, which leaves no time for a second write. The stimulus holds `mem_req_ready` low to freeze the fill on its first request. During the stall it issues an unlock-all and rewrites the address register. After releasing the memory, it shows that the earlier lock survived. A follow-up unlock-line then proves that the address register kept the fill's target. The full-set error is reached by locking both ways of one set and then asking for a third line there. The LRU path is reached by releasing locks with unlock-line and unlock-all and then probing the replacement choice.

// File: rtl/cll_pkg.sv
package cll_pkg;
  localparam logic [2:0] CMD_LOCK_LINE  = 3'b011;
  localparam logic [2:0] CMD_UNLOCK_ONE = 3'b100;
  localparam logic [2:0] CMD_UNLOCK_ALL = 3'b101;

  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_REQ  = 2'd1,
    FE_WAIT = 2'd2
  } fe_state_e;
endpackage

// File: rtl/cll_tag_store.sv
module cll_tag_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 128,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [TAG_W-1:0] a_tag,
  output logic [WAYS-1:0]  a_hit,
  output logic [WAYS-1:0]  a_valid,
  output logic [WAYS-1:0]  a_lock,
  output logic [WAY_W-1:0] a_ptr,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [TAG_W-1:0] b_tag,
  output logic [WAYS-1:0]  b_hit,
  output logic [WAYS-1:0]  b_valid,
  output logic [WAYS-1:0]  b_lock,
  output logic [WAY_W-1:0] b_ptr,
  input  logic             clr_all,
  input  logic             lk_en,
  input  logic             lk_val,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [WAY_W-1:0] lk_way,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [WAY_W-1:0] inv_way,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [WAY_W-1:0] ins_way,
  input  logic [TAG_W-1:0] ins_tag
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  lock_q  [SETS];
  logic [WAY_W-1:0] ptr_q   [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  assign a_valid = valid_q[a_idx];
  assign a_lock  = lock_q[a_idx];
  assign a_ptr   = ptr_q[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_lock  = lock_q[b_idx];
  assign b_ptr   = ptr_q[b_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign a_hit[w] = valid_q[a_idx][w] && (tag_q[a_idx][w] == a_tag);
    assign b_hit[w] = valid_q[b_idx][w] && (tag_q[b_idx][w] == b_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        lock_q[s]  <= '0;
        ptr_q[s]   <= '0;
      end
    end else begin
      if (clr_all) begin
        for (int s = 0; s < SETS; s++) lock_q[s] <= '0;
      end
      if (lk_en) lock_q[lk_idx][lk_way] <= lk_val;
      if (inv_en) begin
        valid_q[inv_idx][inv_way] <= 1'b0;
        lock_q[inv_idx][inv_way]  <= 1'b0;
      end
      if (ins_en) begin
        valid_q[ins_idx][ins_way] <= 1'b1;
        lock_q[ins_idx][ins_way]  <= 1'b1;
        ptr_q[ins_idx] <= (ins_way == WAY_W'(WAYS - 1)) ? '0 : ins_way + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) tag_q[ins_idx][ins_way] <= ins_tag;
  end
endmodule

// File: rtl/cll_victim.sv
module cll_victim #(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  lock,
  input  logic [WAY_W-1:0] ptr,
  output logic             ok,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    ok  = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        ok  = 1'b1;
        way = WAY_W'(w);
      end
    end
    if (!ok) begin
      if (!lock[ptr]) begin
        ok  = 1'b1;
        way = ptr;
      end else begin
        for (int w = WAYS - 1; w >= 0; w--) begin
          if (!lock[w]) begin
            ok  = 1'b1;
            way = WAY_W'(w);
          end
        end
      end
    end
  end
endmodule

// File: rtl/cll_fill_engine.sv
module cll_fill_engine
  import cll_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 4,
  localparam int DW     = 8 * BEAT_BYTES,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BOFF_W = $clog2(BEAT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              wr_en,
  output logic [BEAT_W-1:0] wr_beat,
  output logic [DW-1:0]     wr_data,
  output logic              busy,
  output logic              done_ok,
  output logic              done_err
);
  fe_state_e         st_q;
  logic [BEAT_W-1:0] beat_q;
  logic [AW-1:0]     base_q;
  logic              last;
  logic              take;

  assign last          = (beat_q == BEAT_W'(BEATS - 1));
  assign mem_req_valid = (st_q == FE_REQ);
  assign mem_req_addr  = base_q + AW'({beat_q, {BOFF_W{1'b0}}});
  assign mem_rsp_ready = (st_q == FE_WAIT);
  assign take          = mem_rsp_ready && mem_rsp_valid;
  assign wr_en         = take && !mem_rsp_err;
  assign wr_beat       = beat_q;
  assign wr_data       = mem_rsp_data;
  assign done_ok       = wr_en && last;
  assign done_err      = take && mem_rsp_err;
  assign busy          = (st_q != FE_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FE_IDLE;
      beat_q <= '0;
      base_q <= '0;
    end else begin
      case (st_q)
        FE_IDLE: if (start) begin
          base_q <= base_addr;
          beat_q <= '0;
          st_q   <= FE_REQ;
        end
        FE_REQ: if (mem_req_ready) st_q <= FE_WAIT;
        FE_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err || last) st_q <= FE_IDLE;
          else begin
            beat_q <= beat_q + 1'b1;
            st_q   <= FE_REQ;
          end
        end
        default: st_q <= FE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_lock_ctrl.sv
module cache_lock_ctrl
  import cll_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WAYS       = 2,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 16,
  parameter int BEAT_BYTES = 4,
  parameter logic [AW-1:0] CI_BASE = 32'hFFF0_0000,
  parameter logic [AW-1:0] CI_MASK = 32'hFFF0_0000,
  localparam int DW     = 8 * BEAT_BYTES,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = AW - IDX_W - OFF_W,
  localparam int BEATS  = LINE_BYTES / BEAT_BYTES,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [AW-1:0]     addr_wdata,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_cmd,
  input  logic              ctl_clr_bus,
  input  logic              ctl_clr_nolock,
  output logic              busy,
  output logic              err_bus,
  output logic              err_nolock,
  input  logic [AW-OFF_W-1:0] probe_line,
  output logic              probe_hit,
  output logic [WAY_W-1:0]  probe_way,
  output logic              probe_locked,
  output logic              probe_victim_ok,
  output logic [WAY_W-1:0]  probe_victim_way,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              fill_we,
  output logic [IDX_W-1:0]  fill_set,
  output logic [WAY_W-1:0]  fill_way,
  output logic [BEAT_W-1:0] fill_beat,
  output logic [DW-1:0]     fill_data
);
  logic [AW-1:0]    tgt_q;
  logic [IDX_W-1:0] tgt_idx;
  logic [TAG_W-1:0] tgt_tag;
  logic [IDX_W-1:0] prb_idx;
  logic [TAG_W-1:0] prb_tag;

  logic [WAYS-1:0]  cmd_hit, cmd_valid, cmd_lock;
  logic [WAYS-1:0]  prb_hit, prb_valid, prb_lock;
  logic [WAY_W-1:0] cmd_ptr, prb_ptr;
  logic [WAY_W-1:0] cmd_hit_way;
  logic             cmd_vic_ok;
  logic [WAY_W-1:0] cmd_vic_way;

  logic cmd_go, is_ci, any_hit;
  logic lock_hit, lock_miss, start_fill, no_way, unlock_hit, unlock_all;
  logic done_ok, done_err;

  logic [IDX_W-1:0] f_idx_q;
  logic [WAY_W-1:0] f_way_q;
  logic [TAG_W-1:0] f_tag_q;
  logic             err_bus_q, err_nolock_q;

  assign tgt_idx = tgt_q[OFF_W +: IDX_W];
  assign tgt_tag = tgt_q[AW-1 -: TAG_W];
  assign prb_idx = probe_line[IDX_W-1:0];
  assign prb_tag = probe_line[AW-OFF_W-1 -: TAG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= '0;
    else if (addr_wr && !busy) tgt_q <= addr_wdata;
  end

  always_comb begin
    cmd_hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (cmd_hit[w]) cmd_hit_way = WAY_W'(w);
  end

  always_comb begin
    probe_way = '0;
    for (int w = 0; w < WAYS; w++) if (prb_hit[w]) probe_way = WAY_W'(w);
  end

  assign any_hit    = |cmd_hit;
  assign is_ci      = ((tgt_q & CI_MASK) == CI_BASE);
  assign cmd_go     = ctl_wr && !busy;
  assign lock_hit   = cmd_go && (ctl_cmd == CMD_LOCK_LINE) && !is_ci && any_hit;
  assign lock_miss  = cmd_go && (ctl_cmd == CMD_LOCK_LINE) && !is_ci && !any_hit;
  assign start_fill = lock_miss && cmd_vic_ok;
  assign no_way     = lock_miss && !cmd_vic_ok;
  assign unlock_hit = cmd_go && (ctl_cmd == CMD_UNLOCK_ONE) && any_hit;
  assign unlock_all = cmd_go && (ctl_cmd == CMD_UNLOCK_ALL);

  cll_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .a_idx(tgt_idx), .a_tag(tgt_tag), .a_hit(cmd_hit), .a_valid(cmd_valid),
    .a_lock(cmd_lock), .a_ptr(cmd_ptr),
    .b_idx(prb_idx), .b_tag(prb_tag), .b_hit(prb_hit), .b_valid(prb_valid),
    .b_lock(prb_lock), .b_ptr(prb_ptr),
    .clr_all(unlock_all),
    .lk_en(lock_hit || unlock_hit), .lk_val(lock_hit), .lk_idx(tgt_idx), .lk_way(cmd_hit_way),
    .inv_en(start_fill), .inv_idx(tgt_idx), .inv_way(cmd_vic_way),
    .ins_en(done_ok), .ins_idx(f_idx_q), .ins_way(f_way_q), .ins_tag(f_tag_q)
  );

  cll_victim #(.WAYS(WAYS)) u_vic_cmd (
    .valid(cmd_valid), .lock(cmd_lock), .ptr(cmd_ptr),
    .ok(cmd_vic_ok), .way(cmd_vic_way)
  );

  cll_victim #(.WAYS(WAYS)) u_vic_prb (
    .valid(prb_valid), .lock(prb_lock), .ptr(prb_ptr),
    .ok(probe_victim_ok), .way(probe_victim_way)
  );

  cll_fill_engine #(.AW(AW), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .start(start_fill), .base_addr({tgt_q[AW-1:OFF_W], {OFF_W{1'b0}}}),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .wr_en(fill_we), .wr_beat(fill_beat), .wr_data(fill_data),
    .busy(busy), .done_ok(done_ok), .done_err(done_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_idx_q <= '0;
      f_way_q <= '0;
      f_tag_q <= '0;
    end else if (start_fill) begin
      f_idx_q <= tgt_idx;
      f_way_q <= cmd_vic_way;
      f_tag_q <= tgt_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_bus_q    <= 1'b0;
      err_nolock_q <= 1'b0;
    end else begin
      if (done_err) err_bus_q <= 1'b1;
      else if (ctl_wr && ctl_clr_bus) err_bus_q <= 1'b0;
      if (no_way) err_nolock_q <= 1'b1;
      else if (ctl_wr && ctl_clr_nolock) err_nolock_q <= 1'b0;
    end
  end

  assign err_bus      = err_bus_q;
  assign err_nolock   = err_nolock_q;
  assign probe_hit    = |prb_hit;
  assign probe_locked = |(prb_hit & prb_lock);
  assign fill_set     = f_idx_q;
  assign fill_way     = f_way_q;
endmodule

// File: rtl/cll_checker.sv
module cll_checker #(
  parameter int WAYS = 2,
  parameter int AW   = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [2:0]       ctl_cmd,
  input logic             ctl_clr_bus,
  input logic             ctl_clr_nolock,
  input logic             busy,
  input logic             err_bus,
  input logic             err_nolock,
  input logic             probe_locked,
  input logic             probe_victim_ok,
  input logic [WAY_W-1:0] probe_victim_way,
  input logic [WAYS-1:0]  prb_lock,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_ready,
  input logic             mem_rsp_err
);
  assert_victim_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    probe_victim_ok |-> !prb_lock[probe_victim_way]);

  assert_unlock_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy && ctl_cmd == 3'b101) |=> !probe_locked);

  assert_bus_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bus && !(ctl_wr && ctl_clr_bus)) |=> err_bus);

  assert_nolock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_nolock && !(ctl_wr && ctl_clr_nolock)) |=> err_nolock);

  assert_bus_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_bus) |-> $past(mem_rsp_valid && mem_rsp_ready && mem_rsp_err));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind cache_lock_ctrl cll_checker #(.WAYS(WAYS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_cmd(ctl_cmd),
  .ctl_clr_bus(ctl_clr_bus), .ctl_clr_nolock(ctl_clr_nolock), .busy(busy),
  .err_bus(err_bus), .err_nolock(err_nolock), .probe_locked(probe_locked),
  .probe_victim_ok(probe_victim_ok), .probe_victim_way(probe_victim_way),
  .prb_lock(prb_lock), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready), .mem_rsp_err(mem_rsp_err)
);

// File: tb/cache_lock_ctrl_tb.sv
module cache_lock_ctrl_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        addr_wr = 0, ctl_wr = 0, ctl_clr_bus = 0, ctl_clr_nolock = 0;
  logic [31:0] addr_wdata = 0;
  logic [2:0]  ctl_cmd = 0;
  logic        busy, err_bus, err_nolock;
  logic [27:0] probe_line = 0;
  logic        probe_hit, probe_locked, probe_victim_ok;
  logic [0:0]  probe_way, probe_victim_way;
  logic        mem_req_valid, mem_rsp_ready;
  logic        mem_req_ready = 1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;
  logic        fill_we;
  logic [6:0]  fill_set;
  logic [0:0]  fill_way;
  logic [1:0]  fill_beat;
  logic [31:0] fill_data;

  cache_lock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .ctl_wr(ctl_wr), .ctl_cmd(ctl_cmd), .ctl_clr_bus(ctl_clr_bus), .ctl_clr_nolock(ctl_clr_nolock),
    .busy(busy), .err_bus(err_bus), .err_nolock(err_nolock),
    .probe_line(probe_line), .probe_hit(probe_hit), .probe_way(probe_way),
    .probe_locked(probe_locked), .probe_victim_ok(probe_victim_ok),
    .probe_victim_way(probe_victim_way),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .fill_we(fill_we), .fill_set(fill_set), .fill_way(fill_way),
    .fill_beat(fill_beat), .fill_data(fill_data)
  );

  int n_chk = 0, n_fail = 0, n_we = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  logic [31:0] err_addr = 32'h1;
  logic        pend = 0;
  logic [31:0] paddr = 0;

  // memory model: one response per accepted request
  assign mem_rsp_valid = pend;
  assign mem_rsp_err   = pend && (paddr == err_addr);
  assign mem_rsp_data  = paddr ^ 32'h5A5A_0000;
  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin pend <= 1; paddr <= mem_req_addr; end
    else if (mem_rsp_valid && mem_rsp_ready) pend <= 0;
    if (fill_we) n_we++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every request must match the scoreboard head (R3)
  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (exp_q.size() == 0) chk("R3 unexpected request", mem_req_addr, 32'hxxxx_xxxx);
      else chk("R3 request order", mem_req_addr, exp_q.pop_front());
    end
  end

  function automatic logic [31:0] mk(input int t, input int i);
    return (32'(t) << 11) | (32'(i) << 4);
  endfunction

  task automatic push_fill(input logic [31:0] a, input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(a + 32'(4 * k));
  endtask

  task automatic wr_addr(input logic [31:0] a);
    @(negedge clk); addr_wr = 1; addr_wdata = a;
    @(negedge clk); addr_wr = 0;
  endtask

  task automatic wr_cmd(input logic [2:0] c, input logic cb, input logic cn);
    @(negedge clk); ctl_wr = 1; ctl_cmd = c; ctl_clr_bus = cb; ctl_clr_nolock = cn;
    @(negedge clk); ctl_wr = 0; ctl_clr_bus = 0; ctl_clr_nolock = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic probe(input logic [31:0] a);
    probe_line = a[31:4];
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] A, B, C, D, E, F, X;
    A = mk(1, 5); B = mk(2, 5); C = mk(3, 5); D = mk(4, 7);
    E = mk(5, 8); F = mk(6, 9); X = mk(9, 5);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset busy", 32'(busy), 0);
    chk("R4 reset err_bus", 32'(err_bus), 0);
    chk("R5 reset err_nolock", 32'(err_nolock), 0);
    probe(A); chk("R3 reset no hit", 32'(probe_hit), 0);

    // R3: miss fill into invalid way 0
    wr_addr(A); push_fill(A, 4); wr_cmd(3'b011, 0, 0);
    chk("R10 busy during fill", 32'(busy), 1);
    wait_idle();
    probe(A);
    chk("R3 line valid", 32'(probe_hit), 1);
    chk("R3 line locked", 32'(probe_locked), 1);
    chk("R8 first invalid way", 32'(probe_way), 0);
    chk("R3 fill beats", 32'(n_we), 4);

    // R2: hit locks without bus traffic
    wr_cmd(3'b011, 0, 0);
    chk("R2 no busy on hit", 32'(busy), 0);

    // R8: second line takes invalid way 1
    wr_addr(B); push_fill(B, 4); wr_cmd(3'b011, 0, 0); wait_idle();
    probe(B);
    chk("R8 second way", 32'(probe_way), 1);
    chk("R3 second locked", 32'(probe_locked), 1);

    // R5: full set
    wr_addr(C); wr_cmd(3'b011, 0, 0);
    chk("R5 no busy", 32'(busy), 0);
    chk("R5 err_nolock set", 32'(err_nolock), 1);
    probe(C); chk("R5 nothing allocated", 32'(probe_hit), 0);
    probe(A); chk("R5 A kept", 32'(probe_locked), 1);
    wr_cmd(3'b000, 0, 1);
    chk("R11 nolock cleared", 32'(err_nolock), 0);

    // R6: unlock hit and miss
    wr_addr(B); wr_cmd(3'b100, 0, 0);
    probe(B);
    chk("R6 unlocked", 32'(probe_locked), 0);
    chk("R6 still valid", 32'(probe_hit), 1);
    wr_addr(X); wr_cmd(3'b100, 0, 0);
    probe(A); chk("R6 miss no change", 32'(probe_locked), 1);
    chk("R6 no error", 32'(err_nolock | err_bus), 0);

    // R8: pointer names way 0 but it is locked, so way 1
    probe(A);
    chk("R8 victim ok", 32'(probe_victim_ok), 1);
    chk("R8 skip locked", 32'(probe_victim_way), 1);

    // R7: unlock all
    wr_cmd(3'b101, 0, 0);
    probe(A);
    chk("R7 A unlocked", 32'(probe_locked), 0);
    chk("R7 A valid", 32'(probe_hit), 1);
    chk("R8 LRU choice", 32'(probe_victim_way), 0);

    // R1: unknown codes ignored
    wr_addr(A); wr_cmd(3'b010, 0, 0); wr_cmd(3'b110, 0, 0);
    probe(A);
    chk("R1 ignored code", 32'(probe_locked), 0);
    chk("R1 no busy", 32'(busy), 0);

    // R4: bus error on third beat
    err_addr = D + 8;
    wr_addr(D); push_fill(D, 3); wr_cmd(3'b011, 0, 0); wait_idle();
    chk("R4 err_bus set", 32'(err_bus), 1);
    probe(D); chk("R4 line invalid", 32'(probe_hit), 0);
    err_addr = 32'h1;
    wr_addr(E); push_fill(E, 4); wr_cmd(3'b011, 0, 0); wait_idle();
    chk("R4 sticky", 32'(err_bus), 1);
    wr_cmd(3'b000, 0, 0);
    chk("R11 zero bit keeps", 32'(err_bus), 1);
    wr_cmd(3'b000, 1, 0);
    chk("R11 cleared", 32'(err_bus), 0);

    // R9: caching-inhibited region
    wr_addr(32'hFFF0_0040); wr_cmd(3'b011, 0, 0);
    chk("R9 no busy", 32'(busy), 0);
    probe(32'hFFF0_0040); chk("R9 not allocated", 32'(probe_hit), 0);

    // R10/R12: writes during a stalled fill are ignored
    wr_addr(F);
    @(negedge clk); mem_req_ready = 0;
    push_fill(F, 4); wr_cmd(3'b011, 0, 0);
    wr_cmd(3'b101, 0, 0); wr_addr(E);
    chk("R12 request held", 32'(mem_req_valid), 1);
    chk("R12 address held", mem_req_addr, F);
    @(negedge clk); mem_req_ready = 1;
    wait_idle();
    probe(E); chk("R10 unlock-all ignored", 32'(probe_locked), 1);
    probe(F); chk("R3 F locked", 32'(probe_locked), 1);
    wr_cmd(3'b100, 0, 0);
    probe(F); chk("R10 addr write ignored", 32'(probe_locked), 0);
    probe(E); chk("R10 E untouched", 32'(probe_locked), 1);

    repeat (4) @(negedge clk);
    chk("R3 scoreboard drained", 32'(exp_q.size()), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule